// File: doc/BRIEF.md
# Buffer Descriptor Ring Sequencer

This block keeps a table of buffer descriptors and walks two rings inside it, one for outgoing frames and one for incoming frames. Each descriptor is two 32-bit words: a control/status word and a buffer pointer. The leading descriptors form the transmit ring and the remaining descriptors form the receive ring. A count register sets where the split falls.

Software fills descriptors through a word-addressed host port. When the descriptor at the transmit position is marked ready, the sequencer asks the MAC transmit path to send it and passes on the length, the buffer pointer, and the pad and checksum options. When the MAC reports completion, the sequencer writes the result back and moves to the next descriptor. For each received frame, the sequencer fills the descriptor at the receive position with the frame length and error flags. If that descriptor is not free, the frame is refused. One-cycle event pulses report finished, failed and refused frames. Moving the frame data itself is done elsewhere.

Top module: `bd_ring_seq`

## Requirements
- R1: The host word address is {descriptor index, select}. Select 0 is the status word and select 1 is the buffer pointer. `host_rdata` returns the addressed word in the same cycle. After reset every status word reads 0.
- R2: The transmit count resets to NUM_BD/2. A written value above NUM_BD is stored as NUM_BD. Every count write returns both ring positions to their first descriptor.
- R3: When the status word at the transmit position has bit 15 (ready) set, `tx_req` is high from the next cycle. It carries bits 31:16 as `tx_len`, bit 12 as `tx_pad`, bit 11 as `tx_crc` and the descriptor's pointer as `tx_buf`. These outputs hold, unchanged, until `tx_done` is sampled.
- R4: On `tx_done`, the status word is rewritten with bit 15 cleared and bits 8:0 replaced by `tx_result`. The result bits are: 8 underrun, 7:4 retry count, 3 retry limit, 2 late collision, 1 deferred, 0 carrier lost. All other bits are kept. The transmit position advances only at that moment.
- R5: A ring position returns to the first descriptor of its ring after a descriptor with bit 13 (wrap) set. It also returns there after the last descriptor of its ring: index count-1 for transmit, NUM_BD-1 for receive.
- R6: In the cycle after a transmit write-back, and only if bit 14 (interrupt) of that descriptor is set, exactly one event pulses. `ev_tx_err` pulses if result bit 8, 3, 2 or 0 is set; otherwise `ev_tx_ok` pulses.
- R7: On `rx_valid`, if the receive descriptor (index count + receive position) has bit 15 (empty) set, its status becomes {`rx_len`, 0, kept bits 14:13, 0000, `rx_flags`}. The flag bits are: 8 control frame, 7 missed, 6 overrun, 5 invalid symbol, 4 dribble, 3 too long, 2 too short, 1 CRC error, 0 late collision. `rx_buf` always shows that descriptor's pointer.
- R8: In the cycle after a receive fill, and only if bit 14 is set, `ev_rx_err` pulses if flag bit 6, 5, 3, 2, 1 or 0 is set; otherwise `ev_rx_ok` pulses.
- R9: A frame that meets a non-empty descriptor, or arrives while count equals NUM_BD, leaves every descriptor and the receive position unchanged. `ev_rx_busy` pulses in the next cycle whatever the interrupt bits are.
- R10: While the count is 0, no transmit request is made, whatever the descriptor contents.
- R11: When the host and the engine write the same status word in one cycle, the engine's value is stored. Writes to different words in one cycle all take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | IDX_W+1 | Word address {index, select} |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Addressed word |
| cnt_we | input | 1 | Transmit count write strobe |
| cnt_wdata | input | CNT_W | New transmit count |
| tx_count | output | CNT_W | Current transmit count |
| tx_req | output | 1 | Transmit request |
| tx_len | output | 16 | Frame length to send |
| tx_buf | output | 32 | Frame buffer pointer |
| tx_pad | output | 1 | Pad short frame |
| tx_crc | output | 1 | Append checksum |
| tx_done | input | 1 | Transmit finished |
| tx_result | input | 9 | Transmit completion flags |
| rx_valid | input | 1 | Received frame complete |
| rx_len | input | 16 | Received length including checksum |
| rx_flags | input | 9 | Receive status flags |
| rx_buf | output | 32 | Pointer of current receive descriptor |
| ev_tx_ok | output | 1 | Transmit finished cleanly |
| ev_tx_err | output | 1 | Transmit finished with error |
| ev_rx_ok | output | 1 | Frame stored cleanly |
| ev_rx_err | output | 1 | Frame stored with error |
| ev_rx_busy | output | 1 | Frame refused |

## Verification
A transmit write-back and a host write can land on the same status word in the same cycle. The bench provokes this by raising `tx_done` in the same cycle as a host write to the descriptor being closed. It then reads the word back and expects the engine's closing value. A receive fill is likewise paired with a host write to the neighbouring descriptor, and both words must hold their own new values. A behavioural model running alongside the design compares every output on every clock, so these collisions are also judged cycle by cycle.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  // status word bit positions shared by both rings
  localparam int ST_OWN  = 15;  // tx ready / rx empty
  localparam int ST_IRQ  = 14;
  localparam int ST_WRAP = 13;
  localparam int ST_PAD  = 12;
  localparam int ST_CRC  = 11;

  localparam logic [8:0] TX_FAIL_MASK = 9'h10D;  // underrun, limit, late coll, carrier
  localparam logic [8:0] RX_FAIL_MASK = 9'h06F;  // overrun, symbol, long, short, crc, late coll

  typedef struct packed {
    logic [15:0] len;
    logic        pad;
    logic        crc;
    logic [31:0] bptr;
  } tx_job_t;

  // close a transmit descriptor: bits 31:9 come in, ready dropped, result placed low
  function automatic logic [31:0] tx_close(input logic [22:0] hi, input logic [8:0] res);
    return {hi[22:7], 1'b0, hi[5:0], res};
  endfunction

  function automatic logic [31:0] rx_fill(input logic [15:0] len, input logic [1:0] keep,
                                          input logic [8:0] flags);
    return {len, 1'b0, keep, 4'b0000, flags};
  endfunction
endpackage

// File: rtl/bdr_desc_ram.sv
module bdr_desc_ram
  import bdr_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int IDX_W  = $clog2(NUM_BD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [IDX_W:0]   host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic [IDX_W-1:0] tx_rd_idx,
  output logic             tx_rd_rdy,
  output tx_job_t          tx_rd_job,
  input  logic [IDX_W-1:0] tx_wb_idx,
  output logic [22:0]      tx_wb_cur,
  input  logic             tx_wb_we,
  input  logic [31:0]      tx_wb_data,
  input  logic [IDX_W-1:0] rx_idx,
  output logic [2:0]       rx_cur_flags,
  output logic [31:0]      rx_cur_ptr,
  input  logic             rx_wb_we,
  input  logic [31:0]      rx_wb_data
);
  logic [31:0] stat_q [NUM_BD];
  logic [31:0] ptr_q  [NUM_BD];

  for (genvar g = 0; g < NUM_BD; g++) begin : g_bd
    logic        hit_s, hit_p, stat_en;
    logic [31:0] stat_d, stat_r, ptr_r;

    assign hit_s = host_we && (host_addr[IDX_W:1] == IDX_W'(g)) && !host_addr[0];
    assign hit_p = host_we && (host_addr[IDX_W:1] == IDX_W'(g)) &&  host_addr[0];

    // engine writes outrank the host on the same word
    always_comb begin
      stat_en = 1'b1;
      stat_d  = host_wdata;
      if (rx_wb_we && (rx_idx == IDX_W'(g)))         stat_d = rx_wb_data;
      else if (tx_wb_we && (tx_wb_idx == IDX_W'(g))) stat_d = tx_wb_data;
      else if (!hit_s)                               stat_en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       stat_r <= '0;
      else if (stat_en) stat_r <= stat_d;
    end

    always_ff @(posedge clk) begin
      if (hit_p) ptr_r <= host_wdata;
    end

    assign stat_q[g] = stat_r;
    assign ptr_q[g]  = ptr_r;
  end

  assign host_rdata = host_addr[0] ? ptr_q[host_addr[IDX_W:1]] : stat_q[host_addr[IDX_W:1]];

  assign tx_rd_rdy      = stat_q[tx_rd_idx][ST_OWN];
  assign tx_rd_job.len  = stat_q[tx_rd_idx][31:16];
  assign tx_rd_job.pad  = stat_q[tx_rd_idx][ST_PAD];
  assign tx_rd_job.crc  = stat_q[tx_rd_idx][ST_CRC];
  assign tx_rd_job.bptr = ptr_q[tx_rd_idx];
  assign tx_wb_cur      = stat_q[tx_wb_idx][31:9];
  assign rx_cur_flags   = stat_q[rx_idx][ST_OWN:ST_WRAP];
  assign rx_cur_ptr     = ptr_q[rx_idx];

  // R11: a transmit close is never lost to a host write
  assert_engine_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wb_we && !(rx_wb_we && (rx_idx == tx_wb_idx)))
      |=> (stat_q[$past(tx_wb_idx)] == $past(tx_wb_data)));
endmodule

// File: rtl/bdr_tx_seq.sv
module bdr_tx_seq
  import bdr_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int IDX_W  = $clog2(NUM_BD),
  parameter int CNT_W  = $clog2(NUM_BD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             restart,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_rdy,
  input  tx_job_t          rd_job,
  output logic [IDX_W-1:0] wb_idx,
  input  logic [22:0]      wb_cur,
  output logic             wb_we,
  output logic [31:0]      wb_data,
  output logic             tx_req,
  output tx_job_t          tx_job,
  input  logic             tx_done,
  input  logic [8:0]       tx_result,
  output logic             ev_ok,
  output logic             ev_err
);
  logic             busy_q, busy_d;
  logic [IDX_W-1:0] ptr_q, ptr_d, cap_q;
  tx_job_t          job_q;
  logic             load, ok_d, err_d, last;

  assign rd_idx  = ptr_q;
  assign wb_idx  = cap_q;
  assign wb_data = tx_close(wb_cur, tx_result);
  assign last    = (CNT_W'(cap_q) + CNT_W'(1)) >= count;

  always_comb begin
    busy_d = busy_q;
    ptr_d  = ptr_q;
    load   = 1'b0;
    wb_we  = 1'b0;
    ok_d   = 1'b0;
    err_d  = 1'b0;
    if (!busy_q) begin
      if ((count != '0) && (CNT_W'(ptr_q) < count) && rd_rdy) begin
        load   = 1'b1;
        busy_d = 1'b1;
      end
    end else if (tx_done) begin
      wb_we  = 1'b1;
      busy_d = 1'b0;
      ptr_d  = (wb_cur[ST_WRAP-9] || last) ? '0 : cap_q + IDX_W'(1);
      if (wb_cur[ST_IRQ-9]) begin
        if ((tx_result & TX_FAIL_MASK) != '0) err_d = 1'b1;
        else                                  ok_d  = 1'b1;
      end
    end
    if (restart) ptr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ptr_q  <= '0;
      ev_ok  <= 1'b0;
      ev_err <= 1'b0;
    end else begin
      busy_q <= busy_d;
      ptr_q  <= ptr_d;
      ev_ok  <= ok_d;
      ev_err <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      job_q <= '0;
    end else if (load) begin
      cap_q <= ptr_q;
      job_q <= rd_job;
    end
  end

  assign tx_req = busy_q;
  assign tx_job = job_q;

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_done) |=> (tx_req && $stable(tx_job)));
  assert_event_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ok || ev_err) |-> $past(tx_req && tx_done));
  assert_event_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_ok, ev_err}));
  assert_ptr_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0 && !restart && !$past(restart)) |-> (CNT_W'(ptr_q) < count || busy_q));
endmodule

// File: rtl/bdr_rx_seq.sv
module bdr_rx_seq
  import bdr_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int IDX_W  = $clog2(NUM_BD),
  parameter int CNT_W  = $clog2(NUM_BD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             restart,
  output logic [IDX_W-1:0] cur_idx,
  input  logic [2:0]       cur_flags,
  input  logic             rx_valid,
  input  logic [15:0]      rx_len,
  input  logic [8:0]       rx_flags,
  output logic             wb_we,
  output logic [31:0]      wb_data,
  output logic             ev_ok,
  output logic             ev_err,
  output logic             ev_busy
);
  localparam int AW = CNT_W + 1;

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [AW-1:0]    abs_s;
  logic             in_ring, last, ok_d, err_d, busy_d;

  assign abs_s   = AW'(count) + AW'(ptr_q);
  assign in_ring = abs_s < AW'(NUM_BD);
  assign last    = (abs_s + AW'(1)) >= AW'(NUM_BD);
  assign cur_idx = abs_s[IDX_W-1:0];
  assign wb_data = rx_fill(rx_len, cur_flags[1:0], rx_flags);

  always_comb begin
    ptr_d  = ptr_q;
    wb_we  = 1'b0;
    ok_d   = 1'b0;
    err_d  = 1'b0;
    busy_d = 1'b0;
    if (rx_valid) begin
      if (in_ring && cur_flags[2]) begin
        wb_we = 1'b1;
        ptr_d = (cur_flags[0] || last) ? '0 : ptr_q + IDX_W'(1);
        if (cur_flags[1]) begin
          if ((rx_flags & RX_FAIL_MASK) != '0) err_d = 1'b1;
          else                                 ok_d  = 1'b1;
        end
      end else begin
        busy_d = 1'b1;
      end
    end
    if (restart) ptr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      ev_ok   <= 1'b0;
      ev_err  <= 1'b0;
      ev_busy <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      ev_ok   <= ok_d;
      ev_err  <= err_d;
      ev_busy <= busy_d;
    end
  end

  assert_one_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_ok, ev_err, ev_busy}));
  assert_refused_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !(in_ring && cur_flags[2]) && !restart) |=> (ptr_q == $past(ptr_q)));
  assert_refused_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_busy |-> $past(rx_valid));
endmodule

// File: rtl/bd_ring_seq.sv
module bd_ring_seq
  import bdr_pkg::*;
#(
  parameter int NUM_BD = 128,
  parameter int IDX_W  = $clog2(NUM_BD),
  parameter int CNT_W  = $clog2(NUM_BD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [IDX_W:0]   host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] tx_count,
  output logic             tx_req,
  output logic [15:0]      tx_len,
  output logic [31:0]      tx_buf,
  output logic             tx_pad,
  output logic             tx_crc,
  input  logic             tx_done,
  input  logic [8:0]       tx_result,
  input  logic             rx_valid,
  input  logic [15:0]      rx_len,
  input  logic [8:0]       rx_flags,
  output logic [31:0]      rx_buf,
  output logic             ev_tx_ok,
  output logic             ev_tx_err,
  output logic             ev_rx_ok,
  output logic             ev_rx_err,
  output logic             ev_rx_busy
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] tx_rd_idx, tx_wb_idx, rx_idx;
  logic             tx_rd_rdy, tx_wb_we, rx_wb_we;
  tx_job_t          tx_rd_job, tx_job;
  logic [22:0]      tx_wb_cur;
  logic [31:0]      tx_wb_data, rx_wb_data;
  logic [2:0]       rx_cur_flags;

  assign cnt_d = (cnt_wdata > CNT_W'(NUM_BD)) ? CNT_W'(NUM_BD) : cnt_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(NUM_BD / 2);
    else if (cnt_we) cnt_q <= cnt_d;
  end
  assign tx_count = cnt_q;

  bdr_desc_ram #(.NUM_BD(NUM_BD), .IDX_W(IDX_W)) u_ram (
    .clk, .rst_n, .host_we, .host_addr, .host_wdata, .host_rdata,
    .tx_rd_idx, .tx_rd_rdy, .tx_rd_job, .tx_wb_idx, .tx_wb_cur, .tx_wb_we, .tx_wb_data,
    .rx_idx, .rx_cur_flags, .rx_cur_ptr(rx_buf), .rx_wb_we, .rx_wb_data
  );

  bdr_tx_seq #(.NUM_BD(NUM_BD), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_tx (
    .clk, .rst_n, .count(cnt_q), .restart(cnt_we),
    .rd_idx(tx_rd_idx), .rd_rdy(tx_rd_rdy), .rd_job(tx_rd_job),
    .wb_idx(tx_wb_idx), .wb_cur(tx_wb_cur), .wb_we(tx_wb_we), .wb_data(tx_wb_data),
    .tx_req, .tx_job, .tx_done, .tx_result, .ev_ok(ev_tx_ok), .ev_err(ev_tx_err)
  );

  bdr_rx_seq #(.NUM_BD(NUM_BD), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_rx (
    .clk, .rst_n, .count(cnt_q), .restart(cnt_we),
    .cur_idx(rx_idx), .cur_flags(rx_cur_flags),
    .rx_valid, .rx_len, .rx_flags, .wb_we(rx_wb_we), .wb_data(rx_wb_data),
    .ev_ok(ev_rx_ok), .ev_err(ev_rx_err), .ev_busy(ev_rx_busy)
  );

  assign tx_len = tx_job.len;
  assign tx_buf = tx_job.bptr;
  assign tx_pad = tx_job.pad;
  assign tx_crc = tx_job.crc;

  assert_count_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CNT_W'(NUM_BD));
  assert_idle_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0 && !tx_req) |=> !tx_req);
endmodule

// File: tb/bd_ring_seq_test.sv
module bd_ring_seq_test;
  localparam int NB = 128;
  localparam int IW = 7;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [IW:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic cnt_we = 1'b0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [CW-1:0] tx_count;
  logic tx_req, tx_pad, tx_crc;
  logic [15:0] tx_len;
  logic [31:0] tx_buf, rx_buf;
  logic tx_done = 1'b0;
  logic [8:0] tx_result = '0;
  logic rx_valid = 1'b0;
  logic [15:0] rx_len = '0;
  logic [8:0] rx_flags = '0;
  logic ev_tx_ok, ev_tx_err, ev_rx_ok, ev_rx_err, ev_rx_busy;

  always #10 clk = ~clk;  // 50 MHz

  bd_ring_seq uut (
    .clk, .rst_n, .host_we, .host_addr, .host_wdata, .host_rdata,
    .cnt_we, .cnt_wdata, .tx_count, .tx_req, .tx_len, .tx_buf, .tx_pad, .tx_crc,
    .tx_done, .tx_result, .rx_valid, .rx_len, .rx_flags, .rx_buf,
    .ev_tx_ok, .ev_tx_err, .ev_rx_ok, .ev_rx_err, .ev_rx_busy
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_txok = 0, n_txerr = 0, n_rxok = 0, n_rxerr = 0, n_busy = 0;
  bit cmp_on = 1'b0;

  // behavioural reference model
  logic [31:0] m_stat [NB];
  logic [31:0] m_ptr  [NB];
  bit          m_pv   [NB];
  int m_cnt, m_txp, m_rxp, m_cap;
  bit m_busy, m_pad, m_crc;
  logic [15:0] m_len;
  logic [31:0] m_buf;
  bit e_txok, e_txerr, e_rxok, e_rxerr, e_busy;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit load = 0, wb = 0, rhit = 0;
    int a, ntx, nrx, idx;
    logic [31:0] tw = '0, rw = '0;
    e_txok = 0; e_txerr = 0; e_rxok = 0; e_rxerr = 0; e_busy = 0;
    ntx = m_txp; nrx = m_rxp;
    if (!m_busy) begin
      if (m_cnt > 0 && m_txp < m_cnt && m_stat[m_txp][15]) begin
        load = 1; m_len = m_stat[m_txp][31:16]; m_pad = m_stat[m_txp][12];
        m_crc = m_stat[m_txp][11]; m_buf = m_ptr[m_txp];
      end
    end else if (tx_done) begin
      wb = 1;
      tw = (m_stat[m_cap] & 32'hFFFF_7E00) | {23'b0, tx_result};
      if (m_stat[m_cap][14]) begin
        if ((tx_result & 9'h10D) != 0) e_txerr = 1; else e_txok = 1;
      end
      ntx = (m_stat[m_cap][13] || m_cap + 1 >= m_cnt) ? 0 : m_cap + 1;
    end
    a = m_cnt + m_rxp;
    if (rx_valid) begin
      if (a < NB && m_stat[a][15]) begin
        rhit = 1;
        rw = {rx_len, 1'b0, m_stat[a][14:13], 4'b0000, rx_flags};
        if (m_stat[a][14]) begin
          if ((rx_flags & 9'h06F) != 0) e_rxerr = 1; else e_rxok = 1;
        end
        nrx = (m_stat[a][13] || a + 1 >= NB) ? 0 : m_rxp + 1;
      end else e_busy = 1;
    end
    if (host_we) begin
      idx = int'(host_addr[IW:1]);
      if (host_addr[0]) begin m_ptr[idx] = host_wdata; m_pv[idx] = 1; end
      else m_stat[idx] = host_wdata;
    end
    if (wb) m_stat[m_cap] = tw;
    if (rhit) m_stat[a] = rw;
    if (load) begin m_busy = 1; m_cap = m_txp; end
    else if (wb) m_busy = 0;
    m_txp = ntx; m_rxp = nrx;
    if (cnt_we) begin
      m_cnt = (int'(cnt_wdata) > NB) ? NB : int'(cnt_wdata);
      m_txp = 0; m_rxp = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) m_stat[i] = '0;
      m_cnt = NB / 2; m_txp = 0; m_rxp = 0; m_cap = 0; m_busy = 0;
      e_txok = 0; e_txerr = 0; e_rxok = 0; e_rxerr = 0; e_busy = 0;
    end else model_step();
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_txok += int'(ev_tx_ok); n_txerr += int'(ev_tx_err);
      n_rxok += int'(ev_rx_ok); n_rxerr += int'(ev_rx_err); n_busy += int'(ev_rx_busy);
    end
    if (rst_n && cmp_on) begin
      int a, idx;
      chk(tx_req === m_busy, "R3 tx_req", 32'(tx_req), 32'(m_busy));
      if (m_busy) begin
        chk(tx_len === m_len, "R3 tx_len", 32'(tx_len), 32'(m_len));
        chk(tx_buf === m_buf, "R3 tx_buf", tx_buf, m_buf);
        chk({tx_pad, tx_crc} === {m_pad, m_crc}, "R3 pad/crc", 32'({tx_pad, tx_crc}), 32'({m_pad, m_crc}));
      end
      chk({ev_tx_ok, ev_tx_err} === {e_txok, e_txerr}, "R6 tx events",
          32'({ev_tx_ok, ev_tx_err}), 32'({e_txok, e_txerr}));
      chk({ev_rx_ok, ev_rx_err} === {e_rxok, e_rxerr}, "R8 rx events",
          32'({ev_rx_ok, ev_rx_err}), 32'({e_rxok, e_rxerr}));
      chk(ev_rx_busy === e_busy, "R9 busy event", 32'(ev_rx_busy), 32'(e_busy));
      chk(int'(tx_count) == m_cnt, "R2 tx_count", 32'(tx_count), 32'(m_cnt));
      idx = int'(host_addr[IW:1]);
      if (!host_addr[0]) chk(host_rdata === m_stat[idx], "R1 status read", host_rdata, m_stat[idx]);
      else if (m_pv[idx]) chk(host_rdata === m_ptr[idx], "R1 pointer read", host_rdata, m_ptr[idx]);
      a = m_cnt + m_rxp;
      if (a < NB && m_pv[a]) chk(rx_buf === m_ptr[a], "R7 rx_buf", rx_buf, m_ptr[a]);
    end
  end

  task automatic step(); @(posedge clk); #2; endtask

  task automatic hwrite(input int idx, input bit sel, input logic [31:0] d);
    step(); host_we = 1; host_addr = {IW'(idx), sel}; host_wdata = d;
    step(); host_we = 0;
  endtask

  task automatic hcheck(input int idx, input bit sel, input logic [31:0] exp, input string tag);
    step(); host_addr = {IW'(idx), sel};
    @(negedge clk);
    chk(host_rdata === exp, tag, host_rdata, exp);
  endtask

  task automatic cwrite(input int v);
    step(); cnt_we = 1; cnt_wdata = CW'(v);
    step(); cnt_we = 0;
  endtask

  task automatic tx_run(input logic [15:0] len, input logic [31:0] bp, input bit pad, input logic [8:0] res);
    while (tx_req !== 1'b1) @(negedge clk);
    chk(tx_len === len, "R3 length", 32'(tx_len), 32'(len));
    chk(tx_buf === bp, "R3 buffer", tx_buf, bp);
    chk(tx_pad === pad, "R3 pad", 32'(tx_pad), 32'(pad));
    step(); step();
    @(negedge clk);
    chk(tx_req === 1'b1, "R3 held", 32'(tx_req), 32'd1);
    step(); tx_done = 1; tx_result = res;
    step(); tx_done = 0;
    step(); step();
  endtask

  task automatic rx_frame(input logic [15:0] len, input logic [8:0] fl);
    step(); rx_valid = 1; rx_len = len; rx_flags = fl;
    step(); rx_valid = 0;
    step();
  endtask

  function automatic logic [31:0] pv(input int i); return 32'h1000_0000 + 32'(i) * 32'h600; endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int b0, b1;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    chk(tx_count == CW'(64), "R2 reset count", 32'(tx_count), 32'd64);
    chk(tx_req === 1'b0, "R3 idle after reset", 32'(tx_req), 0);
    hcheck(9, 0, 32'h0, "R1 status zero after reset");
    for (int i = 0; i < NB; i++) hwrite(i, 1, pv(i));
    hcheck(77, 1, pv(77), "R1 pointer readback");

    cwrite(200);
    @(negedge clk) chk(tx_count == CW'(128), "R2 clamp", 32'(tx_count), 32'd128);
    // R9: whole table is transmit, so a frame is refused
    b0 = n_busy;
    rx_frame(16'd64, 9'h0);
    chk(n_busy == b0 + 1, "R9 no receive ring", n_busy, b0 + 1);

    cwrite(0);
    hwrite(0, 0, 32'h003C_D800);
    repeat (4) step();
    @(negedge clk) chk(tx_req === 1'b0, "R10 count zero", 32'(tx_req), 0);
    cwrite(4);

    b0 = n_txok;
    tx_run(16'd60, pv(0), 1, 9'h000);
    chk(n_txok == b0 + 1, "R6 clean event", n_txok, b0 + 1);
    hcheck(0, 0, 32'h003C_5800, "R4 close clean");

    hwrite(1, 0, 32'h0064_C800);
    b0 = n_txerr;
    tx_run(16'd100, pv(1), 0, 9'h134);
    chk(n_txerr == b0 + 1, "R6 error event", n_txerr, b0 + 1);
    hcheck(1, 0, 32'h0064_4934, "R4 close error");

    hwrite(2, 0, 32'h0040_8000);
    b0 = n_txok; b1 = n_txerr;
    tx_run(16'd64, pv(2), 0, 9'h000);
    chk(n_txok + n_txerr == b0 + b1, "R6 no irq no event", n_txok + n_txerr, b0 + b1);
    hcheck(2, 0, 32'h0040_0000, "R4 close no irq");

    hwrite(3, 0, 32'h0050_C000);
    tx_run(16'd80, pv(3), 0, 9'h000);
    hwrite(0, 0, 32'h0030_C000);
    tx_run(16'd48, pv(0), 0, 9'h000);  // R5 end of ring returns to 0
    hwrite(1, 0, 32'h0031_E000);
    tx_run(16'd49, pv(1), 0, 9'h000);
    hwrite(0, 0, 32'h0032_C000);
    tx_run(16'd50, pv(0), 0, 9'h000);  // R5 wrap bit returns to 0

    // R11: host write and transmit close on the same word
    hwrite(1, 0, 32'h0020_C000);
    while (tx_req !== 1'b1) @(negedge clk);
    step(); tx_done = 1; tx_result = 9'h001;
    host_we = 1; host_addr = {IW'(1), 1'b0}; host_wdata = 32'hDEAD_BEEF;
    step(); tx_done = 0; host_we = 0;
    hcheck(1, 0, 32'h0020_4001, "R11 engine wins");

    // receive ring starts at index 4
    hwrite(4, 0, 32'h0000_C000);
    @(negedge clk) chk(rx_buf === pv(4), "R7 rx_buf", rx_buf, pv(4));
    b0 = n_rxok;
    rx_frame(16'd68, 9'h000);
    chk(n_rxok == b0 + 1, "R8 clean event", n_rxok, b0 + 1);
    hcheck(4, 0, 32'h0044_4000, "R7 fill");

    hwrite(5, 0, 32'h0000_E000);
    b0 = n_rxerr;
    rx_frame(16'd70, 9'h002);
    chk(n_rxerr == b0 + 1, "R8 error event", n_rxerr, b0 + 1);
    hcheck(5, 0, 32'h0046_6002, "R7 fill error");
    @(negedge clk) chk(rx_buf === pv(4), "R5 rx wrap", rx_buf, pv(4));

    b0 = n_busy;
    rx_frame(16'd90, 9'h000);
    chk(n_busy == b0 + 1, "R9 busy event", n_busy, b0 + 1);
    hcheck(4, 0, 32'h0044_4000, "R9 descriptor untouched");
    @(negedge clk) chk(rx_buf === pv(4), "R9 position kept", rx_buf, pv(4));

    hwrite(4, 0, 32'h0000_C000);
    b0 = n_rxok;
    rx_frame(16'd72, 9'h010);
    chk(n_rxok == b0 + 1, "R8 dribble is clean", n_rxok, b0 + 1);

    // R11: receive fill and host write to different words together
    hwrite(5, 0, 32'h0000_8000);
    step(); rx_valid = 1; rx_len = 16'd80; rx_flags = 9'h000;
    host_we = 1; host_addr = {IW'(6), 1'b0}; host_wdata = 32'h1234_0000;
    step(); rx_valid = 0; host_we = 0;
    hcheck(5, 0, 32'h0050_0000, "R11 fill lands");
    hcheck(6, 0, 32'h1234_0000, "R11 host lands");

    repeat (3) step();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule